// File: doc/BRIEF.md
# Chopped Sinc3 Decimation Filter

This block turns a one-bit delta-sigma bitstream into decimated conversion results. Each accepted modulator bit counts as +1 (a one) or -1 (a zero) and feeds three cascaded integrators. Once every N accepted bits, three comb differentiators form a third-order sinc result. N comes from a 7-bit filter word, and any word below 3 is raised to 3.

When chopping is enabled, the sign applied to the incoming bits flips at every conversion boundary. Each result taken under reversed polarity is negated, so the wanted signal keeps its sign while an offset added ahead of the filter alternates in sign. Each corrected result is then averaged with the one before it, which cancels that offset.

Changing the filter word or the chop enable restarts the filter. The first three results after a restart are discarded while the comb settles. In chop mode one more result is only held as the first operand of the average. Each published result comes with a one-cycle valid pulse.

Top module: `chop_sinc3_dec`

## Requirements
- R1: After reset, `result` is 0 and `result_vld` is low until the first published result.
- R2: With chop off, every published result equals the sum over the last 3N-2 accepted samples of e[t-k]·h[k], where e is +1 for a one bit and -1 for a zero bit, and h is three length-N boxcars convolved with each other. A constant ones stream gives +N³ and a constant zeros stream gives -N³.
- R3: For filter words 3 to 127 the decimation factor N equals the word: one conversion per N cycles with `mod_en` high.
- R4: A filter word of 0, 1 or 2 behaves exactly like a word of 3.
- R5: A change of filter word or chop enable clears the integrators, comb state and sample counter, and drops the first three conversions that follow.
- R6: With chop on, samples of even-numbered conversions (counted from 0 after a restart) enter with their normal sign, and samples of odd-numbered conversions enter inverted. Each odd-numbered conversion's filter output is negated before further use.
- R7: With chop on, the first conversion after the three dropped ones is only stored. Every later published result is floor((current + previous)/2), using the sign-corrected outputs.
- R8: `result_vld` is high for exactly one cycle per published result, and `result` changes only in that cycle.
- R9: Cycles with `mod_en` low take no sample and leave the filter state unchanged, whatever `mod_bit` is.
- R10: The signed result width is 1+3·7 = 22 bits, and no result's magnitude exceeds N³. At N = 127 this is 2048383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, internally released synchronously |
| mod_en | input | 1 | Qualifies `mod_bit` as a new modulator sample |
| mod_bit | input | 1 | Modulator bit: 1 means +1, 0 means -1 |
| filt_word | input | 7 | Decimation factor; values below 3 act as 3 |
| chop_en | input | 1 | Enables polarity reversal and pairwise averaging |
| result | output | 22 | Signed conversion result |
| result_vld | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The assertions assume that `filt_word` and `chop_en` change only on purpose. They also assume that at least three enabled samples separate two conversions, which the clamp guarantees and on which the one-cycle valid check depends. The bench changes configuration only while `mod_en` is low and after the last pending result has drained, so no conversion is in flight across a restart. Expected values come from an independent convolution of the bench's own ±1 sample history with the triangular sinc3 weights.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int unsigned ORDER       = 3;
  localparam int unsigned FW_DEF      = 7;
  localparam int unsigned MIN_WORD    = 3;
  localparam int unsigned SETTLE_DROP = 3;

  function automatic int unsigned acc_bits(input int unsigned fw);
    return 1 + ORDER * fw;
  endfunction
endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int FW = FW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mod_en,
  input  logic [FW-1:0] word_in,
  input  logic          chop_in,
  output logic          restart,
  output logic          tick,
  output logic          pol_neg,
  output logic          chop_q,
  output logic [FW-1:0] n_q
);
  localparam logic [FW-1:0] WMIN = FW'(MIN_WORD);

  logic [FW-1:0] word_cl, cnt_q, cnt_d, n_d;
  logic          pol_q, pol_d, chop_d;

  always_comb begin
    word_cl = (word_in < WMIN) ? WMIN : word_in;
    restart = (word_cl != n_q) || (chop_in != chop_q);
    tick    = mod_en && !restart && (cnt_q == n_q - 1'b1);
  end

  always_comb begin
    cnt_d  = cnt_q;
    pol_d  = pol_q;
    n_d    = n_q;
    chop_d = chop_q;
    if (restart) begin
      cnt_d  = '0;
      pol_d  = 1'b0;
      n_d    = word_cl;
      chop_d = chop_in;
    end else if (mod_en) begin
      if (tick) begin
        cnt_d = '0;
        pol_d = chop_q ? ~pol_q : 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pol_q  <= 1'b0;
      n_q    <= WMIN;
      chop_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pol_q  <= pol_d;
      n_q    <= n_d;
      chop_q <= chop_d;
    end
  end

  assign pol_neg = pol_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < n_q);
  // R4
  word_floor_chk: assert property (@(posedge clk) disable iff (!rst_n) n_q >= WMIN);
  // R6
  pol_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && chop_q) |=> (pol_q != $past(pol_q)));
  // R6
  pol_plain_chk: assert property (@(posedge clk) disable iff (!rst_n) !chop_q |-> !pol_q);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en && !restart) |=> ($stable(cnt_q) && $stable(pol_q)));
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ
  import sinc3_pkg::*;
#(
  parameter int AW = acc_bits(FW_DEF)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_en,
  input  logic                 clr,
  input  logic                 x_pos,
  output logic signed [AW-1:0] acc_next
);
  localparam logic signed [AW-1:0] PLUS1  = AW'(1);
  localparam logic signed [AW-1:0] MINUS1 = -AW'(1);

  logic signed [AW-1:0] step_val;
  assign step_val = x_pos ? PLUS1 : MINUS1;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic signed [AW-1:0] q, d, feed;
    if (s == 0) begin : g_head
      assign feed = step_val;
    end else begin : g_link
      assign feed = g_stage[s-1].d;
    end
    always_comb d = q + feed;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (clr)     q <= '0;
      else if (step_en) q <= d;
    end
  end

  assign acc_next = g_stage[ORDER-1].d;
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
  import sinc3_pkg::*;
#(
  parameter int FW = FW_DEF,
  parameter int AW = acc_bits(FW_DEF)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 tick,
  input  logic signed [AW-1:0] acc_in,
  input  logic                 neg_in,
  input  logic [FW-1:0]        n_in,
  output logic                 c_vld,
  output logic signed [AW-1:0] c_out,
  output logic                 c_neg
);
  logic signed [AW-1:0] snap_q, snap_d;
  logic                 vld_q, vld_d, neg_q, neg_d;

  always_comb begin
    snap_d = snap_q;
    neg_d  = neg_q;
    vld_d  = 1'b0;
    if (!clr && tick) begin
      snap_d = acc_in;
      neg_d  = neg_in;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      neg_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      snap_q <= snap_d;
      neg_q  <= neg_d;
      vld_q  <= vld_d;
    end
  end

  for (genvar s = 0; s < ORDER; s++) begin : g_diff
    logic signed [AW-1:0] din, o, dly;
    if (s == 0) begin : g_head
      assign din = snap_q;
    end else begin : g_link
      assign din = g_diff[s-1].o;
    end
    always_comb o = din - dly;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dly <= '0;
      else if (clr)   dly <= '0;
      else if (vld_q) dly <= din;
    end
  end

  assign c_out = g_diff[ORDER-1].o;
  assign c_vld = vld_q && !clr;
  assign c_neg = neg_q;

  logic [AW-2:0] cube;
  assign cube = (AW-1)'(n_in) * (AW-1)'(n_in) * (AW-1)'(n_in);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_vld |-> ((c_out <= $signed({1'b0, cube})) && (c_out >= -$signed({1'b0, cube}))));
endmodule

// File: rtl/sinc3_chop_avg.sv
module sinc3_chop_avg
  import sinc3_pkg::*;
#(
  parameter int AW = acc_bits(FW_DEF)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 chop,
  input  logic                 c_vld,
  input  logic signed [AW-1:0] c_in,
  input  logic                 c_neg,
  output logic signed [AW-1:0] result,
  output logic                 result_vld
);
  localparam int DW = $clog2(SETTLE_DROP + 1);
  localparam logic [DW-1:0] DROP = DW'(SETTLE_DROP);

  logic [DW-1:0]        drop_q, drop_d;
  logic                 have_q, have_d, vld_q, vld_d;
  logic signed [AW-1:0] prev_q, prev_d, res_q, res_d, cor, avg;
  logic signed [AW:0]   pair;

  always_comb begin
    cor  = c_neg ? -c_in : c_in;
    pair = {cor[AW-1], cor} + {prev_q[AW-1], prev_q};
    avg  = pair[AW:1];
  end

  always_comb begin
    drop_d = drop_q;
    have_d = have_q;
    prev_d = prev_q;
    res_d  = res_q;
    vld_d  = 1'b0;
    if (clr) begin
      drop_d = DROP;
      have_d = 1'b0;
    end else if (c_vld) begin
      if (drop_q != '0) begin
        drop_d = drop_q - 1'b1;
      end else if (!chop) begin
        res_d = cor;
        vld_d = 1'b1;
      end else if (!have_q) begin
        prev_d = cor;
        have_d = 1'b1;
      end else begin
        res_d  = avg;
        prev_d = cor;
        vld_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= DROP;
      have_q <= 1'b0;
      prev_q <= '0;
      res_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      drop_q <= drop_d;
      have_q <= have_d;
      prev_q <= prev_d;
      res_q  <= res_d;
      vld_q  <= vld_d;
    end
  end

  assign result     = res_q;
  assign result_vld = vld_q;

  // R8
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n) result_vld |=> !result_vld);
  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_vld |-> (result == $past(result)));
  // R5
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) clr |=> !result_vld);
  // R7
  chop_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_vld && chop) |-> $past(have_q));
endmodule

// File: rtl/chop_sinc3_dec.sv
module chop_sinc3_dec
  import sinc3_pkg::*;
#(
  parameter int FW = FW_DEF,
  localparam int AW = acc_bits(FW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mod_en,
  input  logic          mod_bit,
  input  logic [FW-1:0] filt_word,
  input  logic          chop_en,
  output logic [AW-1:0] result,
  output logic          result_vld
);
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic                 restart, tick, pol_neg, chop_q, c_vld, c_neg;
  logic [FW-1:0]        n_q;
  logic signed [AW-1:0] acc_next, c_out, res_s;

  sinc3_ctrl #(.FW(FW)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .mod_en(mod_en), .word_in(filt_word), .chop_in(chop_en),
    .restart(restart), .tick(tick), .pol_neg(pol_neg), .chop_q(chop_q), .n_q(n_q)
  );

  sinc3_integ #(.AW(AW)) u_integ (
    .clk(clk), .rst_n(rst_i), .step_en(mod_en), .clr(restart),
    .x_pos(mod_bit ^ pol_neg), .acc_next(acc_next)
  );

  sinc3_comb #(.FW(FW), .AW(AW)) u_comb (
    .clk(clk), .rst_n(rst_i), .clr(restart), .tick(tick), .acc_in(acc_next),
    .neg_in(pol_neg), .n_in(n_q), .c_vld(c_vld), .c_out(c_out), .c_neg(c_neg)
  );

  sinc3_chop_avg #(.AW(AW)) u_avg (
    .clk(clk), .rst_n(rst_i), .clr(restart), .chop(chop_q), .c_vld(c_vld),
    .c_in(c_out), .c_neg(c_neg), .result(res_s), .result_vld(result_vld)
  );

  assign result = res_s;
endmodule

// File: tb/test_chop_sinc3_dec.sv
`timescale 1ns/1ps
module test_chop_sinc3_dec;
  localparam int FW = 7;
  localparam int AW = 1 + 3 * FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mod_en = 1'b0;
  logic          mod_bit = 1'b0;
  logic          chop_en = 1'b0;
  logic [FW-1:0] filt_word = 7'd5;
  logic [AW-1:0] result;
  logic          result_vld;

  always #5 clk = ~clk;

  chop_sinc3_dec #(.FW(FW)) i_chop_sinc3_dec (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_bit(mod_bit),
    .filt_word(filt_word), .chop_en(chop_en), .result(result), .result_vld(result_vld)
  );

  int n_chk = 0, n_bad = 0, wd = 0;
  int hist [0:383];
  int h    [0:383];
  int mn = 3, mcnt = 0, mneg = 0, mdrop = 3, mhave = 0, mprev = 0, mchop = 0;
  int ticks = 0, outs = 0, last_res = 0;
  bit prev_vld = 0;
  int exp_q[$];
  string tag = "R1";
  logic [15:0] lf = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_cfg(input int w, input int c);
    int b2 [0:255];
    mn = (w < 3) ? 3 : w;
    mchop = c; mcnt = 0; mneg = 0; mdrop = 3; mhave = 0; ticks = 0; outs = 0;
    for (int k = 0; k < 384; k++) begin hist[k] = 0; h[k] = 0; end
    for (int k = 0; k < 256; k++) b2[k] = 0;
    for (int i = 0; i < mn; i++) for (int j = 0; j < mn; j++) b2[i+j]++;
    for (int m = 0; m <= 2*mn-2; m++) for (int j = 0; j < mn; j++) h[m+j] += b2[m];
  endtask

  task automatic model_push(input bit b);
    int y, c;
    for (int k = 383; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = ((b ^ mneg[0]) != 0) ? 1 : -1;
    mcnt++;
    if (mcnt == mn) begin
      mcnt = 0; ticks++;
      y = 0;
      for (int k = 0; k <= 3*mn-3; k++) y += h[k] * hist[k];
      c = (mneg != 0) ? -y : y;
      if (mdrop > 0) mdrop--;
      else if (mchop == 0) exp_q.push_back(c);
      else if (mhave == 0) begin mprev = c; mhave = 1; end
      else begin exp_q.push_back((c + mprev) >>> 1); mprev = c; end
      if (mchop != 0) mneg = 1 - mneg;
    end
  endtask

  task automatic observe();
    int got, e;
    got = int'($signed(result));
    if (result_vld) begin
      outs++;
      if (exp_q.size() == 0) check(1'b0, {tag, " unexpected result"}, got, 0);
      else begin
        e = exp_q.pop_front();
        check(got == e, tag, got, e);
      end
      check(!prev_vld, "R8 single-cycle valid", 1, 0);
    end else begin
      check(got == last_res, "R8 result held", got, last_res);
    end
    prev_vld = result_vld;
    last_res = got;
  endtask

  task automatic cyc(input bit en, input bit b);
    mod_en = en; mod_bit = b;
    if (en) model_push(b);
    @(posedge clk);
    @(negedge clk);
    observe();
  endtask

  function automatic bit pat_bit(input int p, input int i);
    case (p)
      0: return 1'b1;
      1: return 1'b0;
      2: return i[0];
      default: begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
      end
    endcase
  endfunction

  task automatic close_run();
    int expc;
    repeat (6) cyc(1'b0, 1'b0);
    expc = ticks - (3 + mchop);
    if (expc < 0) expc = 0;
    // R3 R5: one conversion per N samples, settling conversions dropped
    check(outs == expc, {tag, " R3 R5 output count"}, outs, expc);
    check(exp_q.size() == 0, {tag, " R5 pending results"}, exp_q.size(), 0);
  endtask

  task automatic configure(input int w, input int c);
    mod_en = 1'b0;
    filt_word = FW'(w);
    chop_en = (c == 0);
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
    chop_en = (c != 0);
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
    model_cfg(w, c);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      $display("FAIL watchdog: got %0d expected %0d", wd, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(result == '0, "R1 result after reset", int'($signed(result)), 0);
    check(result_vld == 1'b0, "R1 valid after reset", int'(result_vld), 0);
    last_res = 0;

    // R2 R3 (chop off) and R6 R7 (chop on): sweep of small factors and patterns
    for (int n = 3; n <= 10; n++)
      for (int c = 0; c < 2; c++)
        for (int p = 0; p < 4; p++) begin
          configure(n, c);
          tag = (c == 0) ? "R2 R3 plain" : "R6 R7 chop";
          for (int i = 0; i < 7*n; i++) cyc(1'b1, pat_bit(p, i));
          close_run();
        end

    // R4: words below the minimum act as 3
    for (int w = 0; w < 3; w++)
      for (int c = 0; c < 2; c++) begin
        configure(w, c);
        tag = "R4 clamp";
        for (int i = 0; i < 24; i++) cyc(1'b1, pat_bit(3, i));
        close_run();
      end

    // R9: idle cycles with a toggling bit leave the state untouched
    configure(6, 1);
    tag = "R9 idle";
    for (int i = 0; i < 18; i++) cyc(1'b1, pat_bit(3, i));
    for (int i = 0; i < 25; i++) cyc(1'b0, pat_bit(3, i));
    for (int i = 0; i < 30; i++) cyc(1'b1, pat_bit(3, i));
    close_run();

    // R10: full-scale at the largest factor, +/-127^3
    configure(127, 0);
    tag = "R10 full scale";
    for (int i = 0; i < 5*127; i++) cyc(1'b1, 1'b1);
    check(last_res == 127*127*127 || exp_q.size() != 0, "R10 positive full scale", last_res, 127*127*127);
    close_run();
    check(last_res == 127*127*127, "R10 positive full scale", last_res, 127*127*127);
    configure(127, 0);
    for (int i = 0; i < 5*127; i++) cyc(1'b1, 1'b0);
    close_run();
    check(last_res == -127*127*127, "R10 negative full scale", last_res, -127*127*127);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule